// File: doc/BRIEF.md
# Grouped Interrupt Mask Gate

This block holds one 8-bit, software-visible mask register and uses it to pass or block interrupt requests a whole group at a time. Six peripheral module groups and one system group each deliver a vector of source flags. Those flags have already been enabled at their sources. The block ORs each group's flags into one group request and ANDs that request with the group's mask bit. It then registers two results: a per-group pending vector for a downstream priority encoder, and a single combined interrupt request.

Software gives each group a priority by choosing which groups to unmask. It reads and writes the mask through a simple select, write strobe and data port. The block never clears or stores a source flag. A blocked request stays at its source until it goes away or its group is unmasked.

Top module: `intmask_gate`

## Requirements
- R1: Mask bits 0 to 5 gate module groups 0 to 5. Module group g drives pending bit g. Within the source-flag bus, group g occupies bits [4g+3:4g].
- R2: Mask bit 7 gates the system group as a whole. The system group drives pending bit 6.
- R3: Mask bit 6 is reserved. It reads as 0 after any write, and it never unmasks any group.
- R4: Reset is synchronous and active high. It clears the mask to 00h and clears both the pending vector and the interrupt request.
- R5: A group's pending bit is 1 exactly when its mask bit was 1 and at least one of its flags was 1 in the cycle before the edge. A cleared mask bit blocks every flag of that group.
- R6: Read data equals the stored mask while the select is high, and 00h otherwise. The mask changes only on an edge where both select and write strobe are high.
- R7: One write replaces all eight mask bits at a single edge. A read in the same cycle as the write returns the value held before that edge.
- R8: The interrupt request is the registered OR of all masked group requests. After a flag changes, it follows at the next edge. After a mask write, it follows at the edge after the write edge.
- R9: Flags are not latched. When a flag drops, its pending bit drops one edge later. A flag that went away while its group was masked causes nothing when the group is later unmasked.
- R10: Any single flag of a group, at any position within the group, is enough to make that group's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select |
| reg_wr | input | 1 | Write strobe, acts only while selected |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, 00h when not selected |
| mod_src_flags | input | 24 | Enabled source flags, 4 per module group, group g at [4g+3:4g] |
| sys_src_flags | input | 4 | Enabled system source flags |
| grp_pending | output | 7 | Masked request per group, bit 6 = system |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The gating is exercised with a set of mask and flag patterns:
- All flags raised under an all-zero mask, and no flags under an all-ones mask. These separate a gate from a plain OR and from a constant.
- Single-flag patterns that place one flag at a different position in each group. These show that each group is reduced over its own slice and that no group or position is swapped.
- Alternating masks against complementary flag patterns. These prove that each mask bit controls only its own group.
- Patterns that set only bit 6, or only bit 7. These separate the reserved bit from the system mask.

Directed sequences then measure the one-edge and two-edge latencies, the same-cycle read, the rule that flags are not latched, writes without select, and reset during activity.

// File: rtl/gim_pkg.sv
package gim_pkg;

    localparam int REG_W      = 8;
    localparam int MOD_GROUPS = 6;
    localparam int NUM_GRPS   = MOD_GROUPS + 1;
    localparam int RSVD_POS   = 6;
    localparam int SYS_POS    = 7;

    // Layout of the mask register; field order follows the bit positions.
    typedef struct packed {
        logic                  sys_en;
        logic                  rsvd;
        logic [MOD_GROUPS-1:0] mod_en;
    } mask_t;

    typedef logic [NUM_GRPS-1:0] grp_vec_t;

    localparam logic [REG_W-1:0] WRITABLE = ~(REG_W'(1) << RSVD_POS);

    // Drop the reserved bit so it can never be stored.
    function automatic mask_t sanitize(input logic [REG_W-1:0] d);
        return mask_t'(d & WRITABLE);
    endfunction

endpackage

// File: rtl/gim_mask_reg.sv
module gim_mask_reg
    import gim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output mask_t            mask_q
);

    logic wr_hit;

    assign wr_hit = sel && wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_hit) begin
            mask_q <= sanitize(wdata);
        end
    end

    // Read returns the current stored value, so a same-cycle write is not seen.
    always_comb begin
        rdata = '0;
        if (sel) begin
            rdata = REG_W'(mask_q);
        end
    end

endmodule

// File: rtl/gim_grp_reduce.sv
module gim_grp_reduce #(
    parameter int GRPS  = 6,
    parameter int WIDTH = 4
) (
    input  logic [GRPS*WIDTH-1:0] flags,
    output logic [GRPS-1:0]       any
);

    for (genvar g = 0; g < GRPS; g++) begin : g_grp
        assign any[g] = |flags[g*WIDTH +: WIDTH];
    end

endmodule

// File: rtl/gim_gate_reg.sv
module gim_gate_reg
    import gim_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [MOD_GROUPS-1:0] mod_en,
    input  logic                  sys_en,
    input  logic [MOD_GROUPS-1:0] mod_any,
    input  logic                  sys_any,
    output grp_vec_t              pending,
    output logic                  irq
);

    grp_vec_t gated;

    always_comb begin
        gated = {sys_en & sys_any, mod_en & mod_any};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            irq     <= 1'b0;
        end else begin
            pending <= gated;
            irq     <= |gated;
        end
    end

endmodule

// File: rtl/intmask_gate.sv
module intmask_gate
    import gim_pkg::*;
#(
    parameter int MOD_SRC_W = 4,
    parameter int SYS_SRC_W = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            reg_sel,
    input  logic                            reg_wr,
    input  logic [REG_W-1:0]                reg_wdata,
    output logic [REG_W-1:0]                reg_rdata,
    input  logic [MOD_GROUPS*MOD_SRC_W-1:0] mod_src_flags,
    input  logic [SYS_SRC_W-1:0]            sys_src_flags,
    output logic [NUM_GRPS-1:0]             grp_pending,
    output logic                            irq_out
);

    mask_t                 mask_q;
    logic [MOD_GROUPS-1:0] mod_any;
    logic [0:0]            sys_any;

    gim_mask_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .sel    (reg_sel),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .mask_q (mask_q)
    );

    gim_grp_reduce #(.GRPS(MOD_GROUPS), .WIDTH(MOD_SRC_W)) u_mod_red (
        .flags (mod_src_flags),
        .any   (mod_any)
    );

    gim_grp_reduce #(.GRPS(1), .WIDTH(SYS_SRC_W)) u_sys_red (
        .flags (sys_src_flags),
        .any   (sys_any)
    );

    gim_gate_reg u_gate (
        .clk     (clk),
        .rst     (rst),
        .mod_en  (mask_q.mod_en),
        .sys_en  (mask_q.sys_en),
        .mod_any (mod_any),
        .sys_any (sys_any[0]),
        .pending (grp_pending),
        .irq     (irq_out)
    );

endmodule

// File: rtl/gim_chk.sv
module gim_chk
    import gim_pkg::*;
#(
    parameter int MOD_SRC_W = 4,
    parameter int SYS_SRC_W = 4
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            reg_sel,
    input logic                            reg_wr,
    input logic [REG_W-1:0]                reg_wdata,
    input logic [REG_W-1:0]                reg_rdata,
    input mask_t                           mask_q,
    input logic [MOD_GROUPS*MOD_SRC_W-1:0] mod_src_flags,
    input logic [SYS_SRC_W-1:0]            sys_src_flags,
    input logic [NUM_GRPS-1:0]             grp_pending,
    input logic                            irq_out
);

    p_rsvd_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[RSVD_POS] == 1'b0);

    p_reset_clears_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mask_q == '0 && grp_pending == '0 && !irq_out));

    p_write_all_bits_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && reg_wr) |=> (REG_W'(mask_q) == ($past(reg_wdata) & WRITABLE)));

    p_no_stray_write_r6: assert property (@(posedge clk) disable iff (rst)
        !(reg_sel && reg_wr) |=> $stable(mask_q));

    p_irq_is_or_r8: assert property (@(posedge clk) disable iff (rst)
        irq_out == (|grp_pending));

    for (genvar g = 0; g < MOD_GROUPS; g++) begin : g_mod
        p_group_gate_r5: assert property (@(posedge clk) disable iff (rst)
            grp_pending[g] |-> $past(mask_q.mod_en[g] && (|mod_src_flags[g*MOD_SRC_W +: MOD_SRC_W])));
        p_group_open_r1: assert property (@(posedge clk) disable iff (rst)
            (mask_q.mod_en[g] && (|mod_src_flags[g*MOD_SRC_W +: MOD_SRC_W])) |=> grp_pending[g]);
    end

    p_sys_gate_r2: assert property (@(posedge clk) disable iff (rst)
        grp_pending[MOD_GROUPS] |-> $past(mask_q.sys_en && (|sys_src_flags)));

endmodule

bind intmask_gate gim_chk #(.MOD_SRC_W(MOD_SRC_W), .SYS_SRC_W(SYS_SRC_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_sel       (reg_sel),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .mask_q        (mask_q),
    .mod_src_flags (mod_src_flags),
    .sys_src_flags (sys_src_flags),
    .grp_pending   (grp_pending),
    .irq_out       (irq_out)
);

// File: tb/tb_intmask_gate.sv
module tb_intmask_gate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [23:0] mod_src_flags = '0;
    logic [3:0]  sys_src_flags = '0;
    logic [6:0]  grp_pending;
    logic        irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    intmask_gate dut (
        .clk           (clk),
        .rst           (rst),
        .reg_sel       (reg_sel),
        .reg_wr        (reg_wr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .mod_src_flags (mod_src_flags),
        .sys_src_flags (sys_src_flags),
        .grp_pending   (grp_pending),
        .irq_out       (irq_out)
    );

    // {mask, module flags, system flags, expected pending}
    localparam int NVEC = 9;
    localparam logic [42:0] VEC [NVEC] = '{
        {8'h00, 24'hFFFFFF, 4'hF, 7'h00},
        {8'hFF, 24'h000000, 4'h0, 7'h00},
        {8'h01, 24'h000001, 4'h0, 7'h01},
        {8'h3F, 24'h218421, 4'h0, 7'h3F},
        {8'h80, 24'hFFFFFF, 4'h8, 7'h40},
        {8'h2A, 24'h0F0F0F, 4'h1, 7'h00},
        {8'h55, 24'h0F0F0F, 4'hF, 7'h15},
        {8'hC0, 24'h000000, 4'h2, 7'h40},
        {8'h20, 24'h800000, 4'h0, 7'h20}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_mask(input logic [7:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4: state after reset
        reg_sel = 1'b1;
        #1;
        check("R4 mask after reset", reg_rdata, 8'h00);
        check("R4 pending after reset", grp_pending, 7'h00);
        check("R4 irq after reset", irq_out, 1'b0);

        // Table walk: R1 R2 R3 R5 R10
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = VEC[i][42:35];
            mod_src_flags = VEC[i][34:11];
            sys_src_flags = VEC[i][10:7];
            @(negedge clk);
            reg_wr = 1'b0;
            check("R3 readback without reserved bit", reg_rdata, VEC[i][42:35] & 8'hBF);
            @(negedge clk);
            check("R1/R2/R5/R10 pending vector", grp_pending, VEC[i][6:0]);
            check("R8 irq from vector", irq_out, |VEC[i][6:0]);
        end

        // R6: read with select low returns 0
        reg_sel = 1'b0;
        #1;
        check("R6 read deselected", reg_rdata, 8'h00);

        // R6: write strobe without select has no effect
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 8'hFF;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b1;
        #1;
        check("R6 unselected write ignored", reg_rdata, 8'h20);

        // R7: same-cycle read returns the old value, then all bits change at once
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h9E;
        #1;
        check("R7 same-cycle read old", reg_rdata, 8'h20);
        @(negedge clk);
        reg_wr = 1'b0;
        check("R7 all bits replaced", reg_rdata, 8'h9E);

        // R8: mask-write latency of two edges
        write_mask(8'h00);
        mod_src_flags = '0; sys_src_flags = '0;
        @(negedge clk);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h01;
        mod_src_flags = 24'h000004;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R8 irq not yet after write edge", irq_out, 1'b0);
        @(negedge clk);
        check("R8 irq one edge after write edge", irq_out, 1'b1);

        // R8/R9: flag drop and rise latency with mask held
        mod_src_flags = '0;
        @(negedge clk);
        check("R9 pending drops with flag", grp_pending, 7'h00);
        check("R8 irq drops with flag", irq_out, 1'b0);
        mod_src_flags = 24'h000002;
        @(negedge clk);
        check("R8 irq follows flag in one edge", irq_out, 1'b1);

        // R9: flag vanished while masked leaves nothing
        write_mask(8'h00);
        @(negedge clk);
        check("R5 masked flag blocked", grp_pending, 7'h00);
        mod_src_flags = '0;
        write_mask(8'h01);
        @(negedge clk);
        check("R9 no latched request", grp_pending, 7'h00);

        // R4: reset during activity
        write_mask(8'hFF);
        mod_src_flags = 24'hFFFFFF; sys_src_flags = 4'hF;
        @(negedge clk);
        check("R1 all groups pending", grp_pending, 7'h7F);
        do_reset();
        reg_sel = 1'b1;
        #1;
        check("R4 mask cleared mid-run", reg_rdata, 8'h00);
        check("R4 pending cleared mid-run", grp_pending, 7'h00);
        check("R4 irq cleared mid-run", irq_out, 1'b0);
        @(negedge clk);
        check("R4 stays blocked after reset", irq_out, 1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule